// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer for Registered Memory Modules

This block sits on the host side of a registered memory module. It moves the module into its deepest power state and brings it back out again. An enter request issues the self-refresh command. The sequencer then idles while that command passes through the module's input register. Next it pulls the module register reset low, which clamps CKE low at the DRAMs. Once the register's deactivation time has passed, it tells the board that the address and control bus may float.

An exit request works in the other direction. The sequencer first waits for the host to report a stable clock. It then counts a PLL lock time derived from the clock frequency and drives a NOP with CKE low. After that it releases the module reset and holds the same levels for the register activation time. Finally it pulses a done flag, so the normal DRAM self-refresh exit procedure can take over.

All waits are parameters in clock cycles. The PLL wait is the product of a clock-rate parameter in MHz and a wait time in microseconds.

Top module: `sr_seq`

## Requirements
- R1: After rst_ni is released, the outputs take the idle pattern: cke_o=1, cs_n_o=ras_n_o=cas_n_o=we_n_o=1 (deselect), mod_rst_n_o=1, bus_drive_o=1, sr_done_o=0 and exit_done_o=0.
- R2: An enter_req_i sampled in idle produces the self-refresh command for exactly one cycle, starting in the next cycle. The command is cke_o=0, cs_n_o=0, ras_n_o=0, cas_n_o=0, we_n_o=1, with mod_rst_n_o=1 and bus_drive_o=1.
- R3: After the command, the block drives deselect with cke_o=0 for PIPE_CYC cycles. It then holds mod_rst_n_o=0 for 1+INACT_CYC cycles, still with deselect, cke_o=0 and bus_drive_o=1.
- R4: In the low-power state the outputs are cke_o=0, mod_rst_n_o=0 and bus_drive_o=0, and all four command lines are low. sr_done_o is high only in the first cycle of this state.
- R5: An exit_req_i sampled in the low-power state moves the block to a clock wait. The wait lasts until clk_stable_i is seen high. PLL_US*CLK_MHZ further cycles with a stable clock then follow, and during all of them the low-power outputs are kept (with sr_done_o=0).
- R6: If clk_stable_i is seen low during the PLL wait, the block returns to the clock wait, and the full PLL count restarts once the clock is stable again.
- R7: After the PLL wait, the block drives for one cycle a NOP (cs_n_o=0, ras_n_o=cas_n_o=we_n_o=1) with cke_o=0, mod_rst_n_o=0 and bus_drive_o=1.
- R8: mod_rst_n_o then rises, and the NOP with cke_o=0 is held for 1+ACT_CYC cycles. One more cycle with the same levels and exit_done_o=1 follows, and then the idle pattern of R1 returns.
- R9: enter_req_i is ignored outside idle, and exit_req_i is ignored outside the low-power state.
- R10: cke_o stays low from the self-refresh command through the exit_done_o cycle, and is low whenever mod_rst_n_o or bus_drive_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enter_req_i | input | 1 | Request to enter self-refresh |
| exit_req_i | input | 1 | Request to leave self-refresh |
| clk_stable_i | input | 1 | Module clock is running and stable |
| cke_o | output | 1 | Clock enable to module |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| mod_rst_n_o | output | 1 | Module register reset, active low |
| bus_drive_o | output | 1 | High when address/control must be driven; low lets the bus float |
| sr_done_o | output | 1 | One-cycle pulse on reaching low power |
| exit_done_o | output | 1 | One-cycle pulse when the DRAM exit procedure may begin |

## Verification
The assertions assume that clk_stable_i only changes state the way a clock monitor would, that requests are level inputs sampled on the clock, and that all wait parameters are at least one. The stimulus mixes random stray requests into every phase and random gaps and dwell times. A delayed clock-stable indication is driven before some exits. In other rounds clk_stable_i drops during the PLL wait, both at a random point and in its last cycle. Each cycle is compared against the expected phase pattern worked out from the parameter values.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SR_CMD,
    ST_PIPE_WAIT,
    ST_RST_ASSERT,
    ST_INACT_WAIT,
    ST_LOW_POWER,
    ST_CLK_WAIT,
    ST_PLL_WAIT,
    ST_DRIVE_NOP,
    ST_RST_RELEASE,
    ST_ACT_WAIT,
    ST_EXIT_READY
  } sr_state_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic mod_rst_n;
    logic drive;
  } pin_set_t;

  localparam pin_set_t PINS_IDLE = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                     we_n: 1'b1, mod_rst_n: 1'b1, drive: 1'b1};

endpackage

// File: rtl/sr_wait_tmr.sv
module sr_wait_tmr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R3
  load_then_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (expired_o == ($past(load_val_i) == '0)));

endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
  import sr_seq_pkg::*;
#(
  parameter int unsigned PIPE_CYC  = 1,
  parameter int unsigned INACT_CYC = 4,
  parameter int unsigned PLL_CYC   = 10000,
  parameter int unsigned ACT_CYC   = 4,
  parameter int unsigned CNT_W     = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_req_i,
  input  logic             exit_req_i,
  input  logic             clk_stable_i,
  input  logic             tmr_expired_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output sr_state_e        state_d_o,
  output logic             sr_done_o,
  output logic             exit_done_o
);

  localparam logic [CNT_W-1:0] PIPE_LD  = CNT_W'(PIPE_CYC - 1);
  localparam logic [CNT_W-1:0] INACT_LD = CNT_W'(INACT_CYC - 1);
  localparam logic [CNT_W-1:0] PLL_LD   = CNT_W'(PLL_CYC - 1);
  localparam logic [CNT_W-1:0] ACT_LD   = CNT_W'(ACT_CYC - 1);

  sr_state_e state_q, state_d;
  logic      sr_done_q, exit_done_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE:        if (enter_req_i) state_d = ST_SR_CMD;
      ST_SR_CMD: begin
        state_d    = ST_PIPE_WAIT;
        tmr_load_o = 1'b1;
        tmr_val_o  = PIPE_LD;
      end
      ST_PIPE_WAIT:   if (tmr_expired_i) state_d = ST_RST_ASSERT;
      ST_RST_ASSERT: begin
        state_d    = ST_INACT_WAIT;
        tmr_load_o = 1'b1;
        tmr_val_o  = INACT_LD;
      end
      ST_INACT_WAIT:  if (tmr_expired_i) state_d = ST_LOW_POWER;
      ST_LOW_POWER:   if (exit_req_i) state_d = ST_CLK_WAIT;
      ST_CLK_WAIT: begin
        if (clk_stable_i) begin
          state_d    = ST_PLL_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = PLL_LD;
        end
      end
      ST_PLL_WAIT: begin
        if (!clk_stable_i)      state_d = ST_CLK_WAIT;
        else if (tmr_expired_i) state_d = ST_DRIVE_NOP;
      end
      ST_DRIVE_NOP:   state_d = ST_RST_RELEASE;
      ST_RST_RELEASE: begin
        state_d    = ST_ACT_WAIT;
        tmr_load_o = 1'b1;
        tmr_val_o  = ACT_LD;
      end
      ST_ACT_WAIT:    if (tmr_expired_i) state_d = ST_EXIT_READY;
      ST_EXIT_READY:  state_d = ST_IDLE;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sr_done_q   <= 1'b0;
      exit_done_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      sr_done_q   <= (state_d == ST_LOW_POWER) && (state_q != ST_LOW_POWER);
      exit_done_q <= (state_d == ST_EXIT_READY);
    end
  end

  assign state_d_o   = state_d;
  assign sr_done_o   = sr_done_q;
  assign exit_done_o = exit_done_q;

  // R2
  enter_only_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SR_CMD) |-> ($past(state_q) == ST_IDLE && $past(enter_req_i)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !enter_req_i) |=> (state_q == ST_IDLE));

  // R9
  low_power_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW_POWER && !exit_req_i) |=> (state_q == ST_LOW_POWER));

  // R6
  pll_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PLL_WAIT && !clk_stable_i) |=> (state_q == ST_CLK_WAIT));

  // R3
  reset_after_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RST_ASSERT) |-> ($past(state_q) == ST_PIPE_WAIT));

endmodule

// File: rtl/sr_pin_dec.sv
module sr_pin_dec
  import sr_seq_pkg::*;
(
  input  sr_state_e state_i,
  output pin_set_t  pins_o
);

  always_comb begin
    pins_o = PINS_IDLE;
    unique case (state_i)
      ST_IDLE:        pins_o = PINS_IDLE;
      ST_SR_CMD:      pins_o = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0,
                                 we_n: 1'b1, mod_rst_n: 1'b1, drive: 1'b1};
      ST_PIPE_WAIT:   pins_o = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                 we_n: 1'b1, mod_rst_n: 1'b1, drive: 1'b1};
      ST_RST_ASSERT,
      ST_INACT_WAIT:  pins_o = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1,
                                 we_n: 1'b1, mod_rst_n: 1'b0, drive: 1'b1};
      ST_LOW_POWER,
      ST_CLK_WAIT,
      ST_PLL_WAIT:    pins_o = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0,
                                 we_n: 1'b0, mod_rst_n: 1'b0, drive: 1'b0};
      ST_DRIVE_NOP:   pins_o = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1,
                                 we_n: 1'b1, mod_rst_n: 1'b0, drive: 1'b1};
      ST_RST_RELEASE,
      ST_ACT_WAIT,
      ST_EXIT_READY:  pins_o = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1,
                                 we_n: 1'b1, mod_rst_n: 1'b1, drive: 1'b1};
      default:        pins_o = PINS_IDLE;
    endcase
  end

endmodule

// File: rtl/sr_seq.sv
module sr_seq
  import sr_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned PLL_US    = 100,
  parameter int unsigned PIPE_CYC  = 1,
  parameter int unsigned INACT_CYC = 4,
  parameter int unsigned ACT_CYC   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_req_i,
  input  logic exit_req_i,
  input  logic clk_stable_i,
  output logic cke_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic mod_rst_n_o,
  output logic bus_drive_o,
  output logic sr_done_o,
  output logic exit_done_o
);

  localparam int unsigned PLL_CYC = CLK_MHZ * PLL_US;
  localparam int unsigned MAX_A   = (PIPE_CYC > INACT_CYC) ? PIPE_CYC : INACT_CYC;
  localparam int unsigned MAX_B   = (PLL_CYC > ACT_CYC) ? PLL_CYC : ACT_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  sr_state_e        state_d;
  pin_set_t         pins_d, pins_q;

  sr_wait_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  sr_fsm #(
    .PIPE_CYC  (PIPE_CYC),
    .INACT_CYC (INACT_CYC),
    .PLL_CYC   (PLL_CYC),
    .ACT_CYC   (ACT_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enter_req_i   (enter_req_i),
    .exit_req_i    (exit_req_i),
    .clk_stable_i  (clk_stable_i),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .state_d_o     (state_d),
    .sr_done_o     (sr_done_o),
    .exit_done_o   (exit_done_o)
  );

  sr_pin_dec u_dec (
    .state_i (state_d),
    .pins_o  (pins_d)
  );

  // Registered pins: glitch-free at the module connector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= PINS_IDLE;
    else         pins_q <= pins_d;
  end

  assign cke_o       = pins_q.cke;
  assign cs_n_o      = pins_q.cs_n;
  assign ras_n_o     = pins_q.ras_n;
  assign cas_n_o     = pins_q.cas_n;
  assign we_n_o      = pins_q.we_n;
  assign mod_rst_n_o = pins_q.mod_rst_n;
  assign bus_drive_o = pins_q.drive;

  // R10
  cke_clamped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_rst_n_o || !bus_drive_o) |-> !cke_o);

  // R4
  float_only_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_drive_o |-> !mod_rst_n_o);

  // R3
  reset_after_cke_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_rst_n_o) |-> (!cke_o && $past(!cke_o) && bus_drive_o));

  // R8
  release_with_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_rst_n_o) |-> (!cke_o && !cs_n_o && ras_n_o && cas_n_o && we_n_o && bus_drive_o));

  // R8
  release_from_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_rst_n_o) |-> ($past(!cs_n_o) && $past(bus_drive_o)));

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_done_o || exit_done_o) |=> (!sr_done_o && !exit_done_o));

endmodule

// File: tb/sim_sr_seq.sv
module sim_sr_seq;

  localparam int P   = 2;
  localparam int I   = 5;
  localparam int A   = 4;
  localparam int MHZ = 100;
  localparam int US  = 1;
  localparam int L   = MHZ * US;

  localparam logic [8:0] V_IDLE = 9'b1_1111_1_1_00;
  localparam logic [8:0] V_SRC  = 9'b0_0001_1_1_00;
  localparam logic [8:0] V_PIPE = 9'b0_1111_1_1_00;
  localparam logic [8:0] V_RSTA = 9'b0_1111_0_1_00;
  localparam logic [8:0] V_LPW  = 9'b0_0000_0_0_00;
  localparam logic [8:0] V_LPWP = 9'b0_0000_0_0_10;
  localparam logic [8:0] V_NOP  = 9'b0_0111_0_1_00;
  localparam logic [8:0] V_ACT  = 9'b0_0111_1_1_00;
  localparam logic [8:0] V_XRDY = 9'b0_0111_1_1_01;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enter_req_i = 1'b0, exit_req_i = 1'b0, clk_stable_i = 1'b1;
  logic cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, mod_rst_n_o, bus_drive_o;
  logic sr_done_o, exit_done_o;
  int   errors = 0, checks = 0;
  int   seed_dummy;

  always #5 clk = ~clk;

  sr_seq #(.CLK_MHZ(MHZ), .PLL_US(US), .PIPE_CYC(P), .INACT_CYC(I), .ACT_CYC(A)) u0 (
    .clk_i (clk), .rst_ni (rst_ni), .enter_req_i (enter_req_i), .exit_req_i (exit_req_i),
    .clk_stable_i (clk_stable_i), .cke_o (cke_o), .cs_n_o (cs_n_o), .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o), .we_n_o (we_n_o), .mod_rst_n_o (mod_rst_n_o),
    .bus_drive_o (bus_drive_o), .sr_done_o (sr_done_o), .exit_done_o (exit_done_o)
  );

  function automatic logic [8:0] obs();
    return {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, mod_rst_n_o, bus_drive_o,
            sr_done_o, exit_done_o};
  endfunction

  function automatic logic [8:0] exp_enter(int k);
    if (k == 0)              return V_SRC;
    else if (k <= P)         return V_PIPE;
    else if (k <= P + 1 + I) return V_RSTA;
    else if (k == P + 2 + I) return V_LPWP;
    else                     return V_LPW;
  endfunction

  function automatic string tag_enter(int k);
    if (k == 0)              return "R2";
    else if (k <= P + 1 + I) return "R3";
    else                     return "R4";
  endfunction

  function automatic logic [8:0] exp_exit(int k);
    if (k <= L)              return V_LPW;
    else if (k == L + 1)     return V_NOP;
    else if (k <= L + 2 + A) return V_ACT;
    else if (k == L + 3 + A) return V_XRDY;
    else                     return V_IDLE;
  endfunction

  function automatic string tag_exit(int k);
    if (k <= L)          return "R5";
    else if (k == L + 1) return "R7";
    else                 return "R8";
  endfunction

  task automatic check(logic [8:0] exp, string req);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, obs(), exp, $time);
    end
  endtask

  task automatic check_cke(logic exp);
    checks++;
    if (cke_o !== exp) begin
      errors++;
      $display("FAIL R10: cke got %b expected %b at %0t", cke_o, exp, $time);
    end
  endtask

  task automatic do_enter();
    enter_req_i = 1'b1;
    exit_req_i  = 1'b0;
    for (int k = 0; k <= P + 3 + I; k++) begin
      @(negedge clk);
      check(exp_enter(k), tag_enter(k));
      check_cke(1'b0);
      enter_req_i = 1'($urandom % 2);                       // R9 stray
      exit_req_i  = (k < P + 2 + I) ? 1'($urandom % 2) : 1'b0;
    end
    enter_req_i = 1'b0;
  endtask

  task automatic do_exit(int pre_wait, int drop_at);
    int  k;
    bit  dropped;
    dropped      = 1'b0;
    clk_stable_i = (pre_wait == 0);
    exit_req_i   = 1'b1;
    enter_req_i  = 1'b0;
    for (int i = 0; i < pre_wait; i++) begin
      @(negedge clk);
      check(V_LPW, "R5");
      exit_req_i = 1'b0;
      if (i == pre_wait - 1) clk_stable_i = 1'b1;
    end
    k = (pre_wait == 0) ? 0 : 1;
    while (k <= L + 4 + A) begin
      @(negedge clk);
      check(exp_exit(k), tag_exit(k));
      if (k <= L + 3 + A) check_cke(1'b0);
      exit_req_i  = 1'($urandom % 2);
      enter_req_i = (k < L + 3 + A) ? 1'($urandom % 2) : 1'b0;
      if (!dropped && k == drop_at) begin
        dropped      = 1'b1;
        clk_stable_i = 1'b0;
        for (int j = 0; j < 3; j++) begin
          @(negedge clk);
          check(V_LPW, "R6");
          if (j == 2) clk_stable_i = 1'b1;
        end
        k = 1;
      end else begin
        k++;
      end
    end
    exit_req_i  = 1'b0;
    enter_req_i = 1'b0;
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(V_IDLE, "R1");
    for (int r = 0; r < 6; r++) begin
      int gap, dwell, pre, drop;
      gap = 2 + int'($urandom % 5);
      for (int g = 0; g < gap; g++) begin
        exit_req_i = 1'($urandom % 2);                      // R9 ignored in idle
        @(negedge clk);
        check(V_IDLE, "R9");
      end
      exit_req_i = 1'b0;
      do_enter();
      dwell = int'($urandom % 5);
      for (int d = 0; d < dwell; d++) begin
        enter_req_i = 1'($urandom % 2);                     // R9 ignored in low power
        @(negedge clk);
        check(V_LPW, "R9");
      end
      enter_req_i = 1'b0;
      pre  = (r % 3 == 1) ? 1 + int'($urandom % 4) : 0;
      drop = (r == 2) ? 1 + int'($urandom % L) : (r == 5) ? L : (r == 4) ? 1 : 0;
      do_exit(pre, drop);
    end
    @(negedge clk);
    check(V_IDLE, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule